// File: doc/BRIEF.md
# Raw-Sample Calibration Packet Serialiser

This block turns one event of unsuppressed front-end data into a fixed-length serial packet. Such packets are used in pedestal, noise and test-pulse runs. An event consists of 128 raw 6-bit ADC samples, a 4-bit crossing number, a 4-bit ASIC count and four 8-bit debug values from the signal-processing chain. The samples are written one per cycle in channel order, and a commit strobe then latches the header fields. The block emits the packet one bit per cycle, most significant bit first. No channel number is transmitted: a sample's channel is its position in the packet.

Storage is double-buffered. While one event is being shifted out, the next event can be written and committed. A load-permit output tells the producer when a free bank exists. A run-level mode input enables raw loading for the whole run. When the mode input is low, the block accepts nothing, but a packet already in flight still completes. After the crossing number, the packet carries a fixed 8-bit marker that no zero-suppressed packet uses. Downstream logic uses this marker to tell raw packets apart from zero-suppressed ones.

Top module: `nzs_calib_packer`

## Requirements
- R1: After reset, `ser_valid` and `pkt_done` are low and `load_ok` equals `raw_mode`.
- R2: The first 12 packet bits are the crossing number (4 bits), then the marker 8'h7F. The marker bits are: a no-data flag of 0, a truncation flag of 1, and a 6-bit length field of all ones. All fields are sent MSB first.
- R3: Bits 12..47 carry, in this order: the ASIC count (4 bits), the common-mode channel count, the signal channel count, the recovered channel count and the common-mode value (8 bits each), all MSB first.
- R4: Bits 48..815 are the 128 samples, 6 bits each, MSB first. The samples go out in ascending channel order. Channel k is the k-th sample written since the previous accepted commit.
- R5: A packet is exactly 816 bits, and `ser_valid` is high on every cycle from its first bit to its last.
- R6: `pkt_done` is high exactly on the cycle that carries the 816th bit, and is low otherwise.
- R7: `cur_chan` is 0 while header bits are on `ser_bit`, and equals the channel of the sample being sent during sample bits.
- R8: A second event can be written and committed while a packet is shifting. `load_ok` is low while both banks hold unsent or in-flight events, and it rises on the cycle `pkt_done` is high.
- R9: Sample writes and commits presented while `load_ok` is low have no effect on later packets.
- R10: With `raw_mode` low, `load_ok` is low and loading is ignored. A packet already in flight completes unchanged.
- R11: Packets leave in commit order. `ser_valid` is low on the cycle after `pkt_done`, and it never rises without a committed event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| raw_mode | input | 1 | Enables raw-event loading for the run |
| smp_valid | input | 1 | Sample write strobe |
| smp_adc | input | 6 | Raw ADC sample, next channel |
| evt_commit | input | 1 | Closes the event and latches header fields |
| evt_bxid | input | 4 | Crossing number |
| evt_asic_cnt | input | 4 | ASIC count |
| evt_cm_chans | input | 8 | Debug: common-mode channel count |
| evt_sig_chans | input | 8 | Debug: signal channel count |
| evt_rec_chans | input | 8 | Debug: recovered channel count |
| evt_cm_value | input | 8 | Debug: common-mode value |
| load_ok | output | 1 | A bank is free and raw mode is on |
| ser_bit | output | 1 | Serial packet bit |
| ser_valid | output | 1 | `ser_bit` carries a packet bit |
| pkt_done | output | 1 | Last bit of a packet |
| cur_chan | output | 7 | Channel of the sample on `ser_bit` |

## Verification
The bench builds the block with its default parameters: 128 channels of 6 bits and a 48-bit header, which gives the full 816-bit packet. With these sizes, loading the next event takes 129 cycles, well inside the 816-cycle shift. This lets the bench fill both banks, attempt a refused load, and then drop the run mode while one event is still pending. Events with all-ones and all-zero fields and samples exercise every bit position of every field.

// File: rtl/nzs_pkg.sv
package nzs_pkg;
    localparam int unsigned BX_W    = 4;
    localparam int unsigned MARK_W  = 8;
    localparam int unsigned NASIC_W = 4;
    localparam int unsigned DBG_W   = 8;
    localparam int unsigned DBG_N   = 4;
    localparam int unsigned ADC_W   = 6;
    localparam int unsigned N_CHAN  = 128;
    // no-data flag 0, truncation flag 1, length field all ones
    localparam logic [MARK_W-1:0] RAW_MARK = 8'h7F;
    localparam int unsigned HDR_W   = BX_W + MARK_W + NASIC_W + DBG_N * DBG_W;
endpackage

// File: rtl/nzs_bank_store.sv
module nzs_bank_store #(
    parameter int unsigned N_CHAN = nzs_pkg::N_CHAN,
    parameter int unsigned ADC_W  = nzs_pkg::ADC_W,
    parameter int unsigned HDR_W  = nzs_pkg::HDR_W,
    localparam int unsigned CH_W  = $clog2(N_CHAN),
    localparam int unsigned PTR_W = $clog2(N_CHAN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_i,
    input  logic              wr_vld_i,
    input  logic [ADC_W-1:0]  wr_adc_i,
    input  logic              commit_i,
    input  logic [HDR_W-1:0]  hdr_i,
    input  logic              rel_i,
    input  logic [CH_W-1:0]   rd_idx_i,
    output logic              load_ok_o,
    output logic              rd_avail_o,
    output logic [HDR_W-1:0]  rd_hdr_o,
    output logic [ADC_W-1:0]  rd_adc_o
);
    typedef struct packed {
        logic [1:0][N_CHAN-1:0][ADC_W-1:0] mem;
        logic [1:0][HDR_W-1:0]             hdr;
        logic [1:0]                        full;
        logic                              wbank;
        logic                              rbank;
        logic [PTR_W-1:0]                  wr_ptr;
    } bank_t;

    bank_t s_d, s_q;
    logic  wr_ok;

    assign wr_ok = mode_i && !s_q.full[s_q.wbank];

    always_comb begin
        s_d = s_q;
        if (wr_ok && wr_vld_i && (s_q.wr_ptr < PTR_W'(N_CHAN))) begin
            s_d.mem[s_q.wbank][s_q.wr_ptr[CH_W-1:0]] = wr_adc_i;
            s_d.wr_ptr = s_q.wr_ptr + 1'b1;
        end
        if (wr_ok && commit_i) begin
            s_d.hdr[s_q.wbank]  = hdr_i;
            s_d.full[s_q.wbank] = 1'b1;
            s_d.wbank           = ~s_q.wbank;
            s_d.wr_ptr          = '0;
        end
        if (rel_i) begin
            s_d.full[s_q.rbank] = 1'b0;
            s_d.rbank           = ~s_q.rbank;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign load_ok_o  = wr_ok;
    assign rd_avail_o = s_q.full[s_q.rbank];
    assign rd_hdr_o   = s_q.hdr[s_q.rbank];
    assign rd_adc_o   = s_q.mem[s_q.rbank][rd_idx_i];

    AST_BLOCKED_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load_ok_o |=> $stable(s_q.wr_ptr)); // R9
    AST_RELEASE_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        rel_i |-> rd_avail_o); // R8
    AST_OFF_MODE_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_i |-> !load_ok_o); // R10
endmodule

// File: rtl/nzs_bit_sequencer.sv
module nzs_bit_sequencer #(
    parameter int unsigned N_CHAN = nzs_pkg::N_CHAN,
    parameter int unsigned ADC_W  = nzs_pkg::ADC_W,
    parameter int unsigned HDR_W  = nzs_pkg::HDR_W,
    localparam int unsigned PKT_LEN = HDR_W + N_CHAN * ADC_W,
    localparam int unsigned POS_W   = $clog2(PKT_LEN),
    localparam int unsigned CH_W    = $clog2(N_CHAN),
    localparam int unsigned SUB_W   = $clog2(ADC_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             avail_i,
    input  logic [HDR_W-1:0] hdr_i,
    input  logic [ADC_W-1:0] adc_i,
    output logic [CH_W-1:0]  rd_idx_o,
    output logic             rel_o,
    output logic             ser_bit_o,
    output logic             ser_valid_o,
    output logic             done_o,
    output logic [CH_W-1:0]  chan_o
);
    typedef struct packed {
        logic              busy;
        logic [POS_W-1:0]  pos;
        logic [CH_W-1:0]   idx;
        logic [SUB_W-1:0]  sub;
        logic              bit_o;
        logic              vld_o;
        logic              done_o;
        logic [CH_W-1:0]   chan_o;
    } seq_t;

    seq_t s_d, s_q;
    logic [HDR_W-1:0] hdr_sh;
    logic [ADC_W-1:0] adc_sh;
    logic             in_hdr;

    assign hdr_sh = hdr_i << s_q.pos;
    assign adc_sh = adc_i << s_q.sub;
    assign in_hdr = s_q.pos < POS_W'(HDR_W);

    always_comb begin
        s_d        = s_q;
        s_d.vld_o  = 1'b0;
        s_d.done_o = 1'b0;
        rel_o      = 1'b0;
        if (!s_q.busy) begin
            if (avail_i) begin
                s_d.busy = 1'b1;
                s_d.pos  = '0;
                s_d.idx  = '0;
                s_d.sub  = '0;
            end
        end else begin
            s_d.bit_o  = in_hdr ? hdr_sh[HDR_W-1] : adc_sh[ADC_W-1];
            s_d.vld_o  = 1'b1;
            s_d.chan_o = in_hdr ? '0 : s_q.idx;
            if (s_q.pos == POS_W'(PKT_LEN - 1)) begin
                s_d.done_o = 1'b1;
                s_d.busy   = 1'b0;
                rel_o      = 1'b1;
            end else begin
                s_d.pos = s_q.pos + 1'b1;
                if (!in_hdr) begin
                    if (s_q.sub == SUB_W'(ADC_W - 1)) begin
                        s_d.sub = '0;
                        s_d.idx = s_q.idx + 1'b1;
                    end else begin
                        s_d.sub = s_q.sub + 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rd_idx_o    = s_q.idx;
    assign ser_bit_o   = s_q.bit_o;
    assign ser_valid_o = s_q.vld_o;
    assign done_o      = s_q.done_o;
    assign chan_o      = s_q.chan_o;

    AST_DONE_WITH_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ser_valid_o); // R6
    AST_GAP_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !ser_valid_o); // R11
    AST_START_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.busy) |-> $past(avail_i)); // R11
    AST_CHAN_NONDECREASING: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_valid_o && $past(ser_valid_o)) |-> (chan_o >= $past(chan_o))); // R7
    AST_POS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.busy |-> (s_q.pos < POS_W'(PKT_LEN))); // R5
endmodule

// File: rtl/nzs_calib_packer.sv
module nzs_calib_packer #(
    parameter int unsigned N_CHAN  = nzs_pkg::N_CHAN,
    parameter int unsigned ADC_W   = nzs_pkg::ADC_W,
    parameter int unsigned BX_W    = nzs_pkg::BX_W,
    parameter int unsigned NASIC_W = nzs_pkg::NASIC_W,
    parameter int unsigned DBG_W   = nzs_pkg::DBG_W,
    localparam int unsigned HDR_W  = BX_W + nzs_pkg::MARK_W + NASIC_W + 4 * DBG_W,
    localparam int unsigned CH_W   = $clog2(N_CHAN)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               raw_mode,
    input  logic               smp_valid,
    input  logic [ADC_W-1:0]   smp_adc,
    input  logic               evt_commit,
    input  logic [BX_W-1:0]    evt_bxid,
    input  logic [NASIC_W-1:0] evt_asic_cnt,
    input  logic [DBG_W-1:0]   evt_cm_chans,
    input  logic [DBG_W-1:0]   evt_sig_chans,
    input  logic [DBG_W-1:0]   evt_rec_chans,
    input  logic [DBG_W-1:0]   evt_cm_value,
    output logic               load_ok,
    output logic               ser_bit,
    output logic               ser_valid,
    output logic               pkt_done,
    output logic [CH_W-1:0]    cur_chan
);
    logic [HDR_W-1:0] hdr_in, rd_hdr;
    logic [ADC_W-1:0] rd_adc;
    logic [CH_W-1:0]  rd_idx;
    logic             rd_avail, rel;

    assign hdr_in = {evt_bxid, nzs_pkg::RAW_MARK, evt_asic_cnt,
                     evt_cm_chans, evt_sig_chans, evt_rec_chans, evt_cm_value};

    nzs_bank_store #(.N_CHAN(N_CHAN), .ADC_W(ADC_W), .HDR_W(HDR_W)) u_store (
        .clk(clk), .rst_n(rst_n), .mode_i(raw_mode),
        .wr_vld_i(smp_valid), .wr_adc_i(smp_adc),
        .commit_i(evt_commit), .hdr_i(hdr_in),
        .rel_i(rel), .rd_idx_i(rd_idx),
        .load_ok_o(load_ok), .rd_avail_o(rd_avail),
        .rd_hdr_o(rd_hdr), .rd_adc_o(rd_adc)
    );

    nzs_bit_sequencer #(.N_CHAN(N_CHAN), .ADC_W(ADC_W), .HDR_W(HDR_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .avail_i(rd_avail),
        .hdr_i(rd_hdr), .adc_i(rd_adc),
        .rd_idx_o(rd_idx), .rel_o(rel),
        .ser_bit_o(ser_bit), .ser_valid_o(ser_valid),
        .done_o(pkt_done), .chan_o(cur_chan)
    );

    AST_NOT_READY_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !ser_valid); // R1
endmodule

// File: tb/tb_nzs_calib_packer.sv
module tb_nzs_calib_packer;
    localparam int CLK_PERIOD = 10;
    localparam int PKT_BITS   = 816;
    localparam int HDR_BITS   = 48;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic raw_mode = 1'b1;
    logic smp_valid = 1'b0;
    logic [5:0] smp_adc = '0;
    logic evt_commit = 1'b0;
    logic [3:0] evt_bxid = '0, evt_asic_cnt = '0;
    logic [7:0] evt_cm_chans = '0, evt_sig_chans = '0, evt_rec_chans = '0, evt_cm_value = '0;
    logic load_ok, ser_bit, ser_valid, pkt_done;
    logic [6:0] cur_chan;

    nzs_calib_packer dut (
        .clk(clk), .rst_n(rst_n), .raw_mode(raw_mode),
        .smp_valid(smp_valid), .smp_adc(smp_adc), .evt_commit(evt_commit),
        .evt_bxid(evt_bxid), .evt_asic_cnt(evt_asic_cnt),
        .evt_cm_chans(evt_cm_chans), .evt_sig_chans(evt_sig_chans),
        .evt_rec_chans(evt_rec_chans), .evt_cm_value(evt_cm_value),
        .load_ok(load_ok), .ser_bit(ser_bit), .ser_valid(ser_valid),
        .pkt_done(pkt_done), .cur_chan(cur_chan)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int checks = 0, failures = 0;
    int occ = 0;
    int pos = 0;
    int cycles = 0;
    bit prev_done = 0;
    bit mon_on = 0;
    bit exp_q[$];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    function automatic int fld(input int id, input int k);
        if (id == 3) return (k < 2) ? 15 : 255;
        if (id == 4) return 0;
        if (k == 0) return (id * 5 + 3) & 15;
        if (k == 1) return (id + 6) & 15;
        return (id * 37 + k * 53 + 17) & 255;
    endfunction

    function automatic int samp(input int id, input int ch);
        if (id == 3) return 63;
        if (id == 4) return 0;
        return (ch * 7 + id * 13 + ch / 16) & 63;
    endfunction

    task automatic push_field(input int val, input int w);
        for (int i = w - 1; i >= 0; i--) exp_q.push_back(bit'((val >> i) & 1));
    endtask

    task automatic send_event(input int id, input bit accepted);
        for (int ch = 0; ch < 128; ch++) begin
            @(posedge clk); #1;
            smp_valid = 1'b1;
            smp_adc   = 6'(samp(id, ch));
        end
        @(posedge clk); #1;
        smp_valid     = 1'b0;
        evt_commit    = 1'b1;
        evt_bxid      = 4'(fld(id, 0));
        evt_asic_cnt  = 4'(fld(id, 1));
        evt_cm_chans  = 8'(fld(id, 2));
        evt_sig_chans = 8'(fld(id, 3));
        evt_rec_chans = 8'(fld(id, 4));
        evt_cm_value  = 8'(fld(id, 5));
        @(posedge clk); #1;
        evt_commit = 1'b0;
        if (accepted) begin
            occ++;
            push_field(fld(id, 0), 4);
            push_field(8'h7F, 8);       // R2 marker
            push_field(fld(id, 1), 4);  // R3 field order
            for (int k = 2; k < 6; k++) push_field(fld(id, k), 8);
            for (int ch = 0; ch < 128; ch++) push_field(samp(id, ch), 6); // R4
        end
    endtask

    // per-cycle reference comparison
    always @(negedge clk) begin
        if (mon_on) begin
            if (ser_valid) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R11 bit without committed event", 1, 0);
                end else begin
                    bit eb;
                    eb = exp_q.pop_front();
                    chk(ser_bit == eb, (pos < 12) ? "R2" : (pos < HDR_BITS) ? "R3" : "R4",
                        ser_bit, eb);
                    chk(int'(cur_chan) == ((pos < HDR_BITS) ? 0 : (pos - HDR_BITS) / 6),
                        "R7", cur_chan, (pos < HDR_BITS) ? 0 : (pos - HDR_BITS) / 6);
                    chk(pkt_done == (pos == PKT_BITS - 1), "R6", pkt_done, pos == PKT_BITS - 1);
                    pos++;
                    if (pos == PKT_BITS) begin
                        pos = 0;
                        occ--;
                    end
                end
                if (prev_done) chk(0, "R11 no gap after done", 1, 0);
            end else begin
                chk(pkt_done == 1'b0, "R6", pkt_done, 0);
                if (pos != 0) chk(0, "R5 packet interrupted", pos, PKT_BITS);
            end
            prev_done = pkt_done;
            chk(load_ok == (raw_mode && occ < 2), raw_mode ? "R8" : "R10",
                load_ok, raw_mode && occ < 2);
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(ser_valid == 1'b0, "R1", ser_valid, 0);
        chk(pkt_done == 1'b0, "R1", pkt_done, 0);
        chk(load_ok == raw_mode, "R1", load_ok, raw_mode);
        mon_on = 1'b1;
        send_event(0, 1);
        send_event(1, 1);            // R8: loaded while event 0 shifts
        @(negedge clk);
        chk(load_ok == 1'b0, "R8 both banks held", load_ok, 0);
        send_event(9, 0);            // R9: refused load must not appear
        @(negedge clk);
        chk(load_ok == 1'b0, "R9 refused load left no trace", load_ok, 0);
        while (occ >= 2) @(negedge clk);
        send_event(2, 1);
        @(posedge clk); #1 raw_mode = 1'b0;
        while (occ >= 2) @(negedge clk);
        @(negedge clk);
        chk(load_ok == 1'b0, "R10 mode off blocks load", load_ok, 0);
        send_event(9, 0);            // R10: ignored with mode low
        @(posedge clk); #1 raw_mode = 1'b1;
        while (occ >= 2) @(negedge clk);
        send_event(3, 1);
        while (occ >= 2) @(negedge clk);
        send_event(4, 1);
        while (occ > 0 || exp_q.size() != 0) @(negedge clk);
        repeat (5) @(negedge clk);
        chk(exp_q.size() == 0, "R11 all packets out", exp_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            chk(0, "watchdog expired", cycles, 100000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule